// File: doc/BRIEF.md
# Event-Stepped Countdown Timer with Optional Periodic Reload

This block is a timer peripheral with one register on a simple strobe/acknowledge slave port. A write to the register loads a countdown value and chooses the mode. The top bit of the written word asks for periodic reload, and the low bits give the count. The counter steps down by one only on cycles where the count-enable input is high. That input can be tied high to count clock cycles, or pulsed once per sample, line, frame or any other event.

When an enabled step takes the count from 1 to 0, the interrupt output pulses for one cycle. In one-shot mode the timer then stays idle at zero. In periodic mode the next enabled step reloads the stored interval, so a count of N gives an interrupt every N+1 enabled steps. A read returns the periodic-mode flag in the top bit and the live count in the low bits.

A parameter removes the reload hardware, and the timer is then one-shot only. The counter width must be at most two less than the bus width. Reset is synchronous and active low.

Top module: `evt_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count and the periodic flag become 0, and `irq` and `bus_ack` become 0. A write in the same cycle as reset is discarded.
- R2: A write (`bus_stb` and `bus_we` both high) loads the count from `bus_wdata[CNT_W-1:0]` at the next edge. Writing a count of zero leaves the timer stopped at zero and clears periodic mode.
- R3: A write enters periodic mode only when `bus_wdata[DATA_W-1]` is 1 and the count field is non-zero. Every other write selects one-shot mode.
- R4: In periodic mode, an enabled step taken at count 0 reloads the last written count, so a count N repeats every N+1 enabled steps. In one-shot mode the count stays at 0.
- R5: The count changes only on edges where `cnt_en` is high, the timer is running (count non-zero or periodic mode), and no write is present. With `cnt_en` low it holds.
- R6: `irq` is high for exactly the cycle after an enabled step from count 1 to count 0. It is low after reset, while idle, and while waiting at zero for an enable before a reload.
- R7: A write in the same cycle as an enabled step at count 1 loads the new count, and no interrupt follows.
- R8: `bus_stall` is always 0. `bus_ack` is high in the cycle after each cycle in which `bus_stb` is high, for both reads and writes, and low otherwise. A strobe without `bus_we` changes nothing.
- R9: `bus_rdata` gives the periodic flag in bit DATA_W-1, the count in bits CNT_W-1:0, and zero in all the bits between them. Written bits between the count field and the top bit are ignored.
- R10: With `RELOAD_EN` = 0, the periodic flag always reads 0, and a write with the top bit set behaves as a one-shot write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count-enable: one step per high cycle |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | DATA_W | Write word: mode bit on top, count in the low bits |
| bus_ack | output | 1 | Acknowledge, one cycle after a strobe |
| bus_stall | output | 1 | Stall, always 0 |
| bus_rdata | output | DATA_W | Periodic flag and current count |
| irq | output | 1 | One-cycle interrupt when the count reaches zero |

## Verification
A bus write can arrive in the same cycle as an enabled step. The step may be either the final 1-to-0 step or a periodic reload at zero. The bench provokes the first case by counting a one-shot load down to 1 with `cnt_en` held high and issuing a new write on that same cycle. It judges the result at the ports: the read-back count must equal the new value, and `irq` must stay low on the following cycle and on the cycle after that. Reset arriving with a write is provoked the same way, and the only acceptable outcome is an idle timer.

// File: rtl/tmr_pkg.sv
// Shared types for the countdown timer.
// Assumes: nothing; holds no logic.
package tmr_pkg;
    // Operating mode held by the control register
    typedef enum logic {
        TMR_ONESHOT  = 1'b0,
        TMR_PERIODIC = 1'b1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_ctrl.sv
// Write decode, mode flag and reload interval register.
// Assumes: wcount/wmode are already split from the bus word; when RELOAD_EN
// is 0 the mode and interval are constant zero and synthesis drops them.
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter bit RELOAD_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_stb,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] wcount,
    input  logic             wmode,
    output logic             wr_o,
    output logic             auto_o,
    output logic [CNT_W-1:0] interval_o
);
    assign wr_o = bus_stb && bus_we;

    generate
        if (RELOAD_EN) begin : g_reload
            tmr_mode_e        mode_q;
            logic [CNT_W-1:0] ival_q;

            // Mode: periodic only when requested with a non-zero count
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mode_q <= TMR_ONESHOT;
                else if (wr_o)
                    mode_q <= (wmode && (wcount != '0)) ? TMR_PERIODIC : TMR_ONESHOT;
            end

            // Interval: every write stores its count
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ival_q <= '0;
                else if (wr_o)
                    ival_q <= wcount;
            end

            assign auto_o     = (mode_q == TMR_PERIODIC);
            assign interval_o = ival_q;

            // R3
            periodic_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_o && wmode && (wcount != '0)) |=> auto_o);
            // R3
            oneshot_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_o && (!wmode || (wcount == '0))) |=> !auto_o);
            // R4
            interval_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                auto_o |-> (interval_o != '0));
        end else begin : g_oneshot
            assign auto_o     = 1'b0;
            assign interval_o = '0;
            logic unused_ctrl;
            assign unused_ctrl = wmode ^ (^wcount) ^ clk ^ rst_n;
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
// Countdown register, registered zero flag and interrupt pulse.
// Assumes: auto implies interval != 0 (guaranteed by tmr_ctrl); a write
// always wins over a count step in the same cycle.
module tmr_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr,
    input  logic [CNT_W-1:0] wcount,
    input  logic             auto,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] value_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] value_q;
    logic             zero_q;
    logic             irq_q;
    logic             running;
    logic             step;
    logic             at_one;

    assign running = !zero_q || auto;
    assign step    = cnt_en && running;
    assign at_one  = (value_q == ONE);

    // Counter: load on write, decrement or reload on an enabled step
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= '0;
        else if (wr)
            value_q <= wcount;
        else if (step)
            value_q <= zero_q ? interval : (value_q - ONE);
    end

    // Zero flag: predicted one step ahead so no wide compare sits on it
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_q <= 1'b1;
        else if (wr)
            zero_q <= (wcount == '0);
        else if (step)
            zero_q <= zero_q ? 1'b0 : at_one;
    end

    // Interrupt: one pulse on a counted 1-to-0 step not pre-empted by a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= !wr && cnt_en && at_one;
    end

    assign value_o = value_q;
    assign irq_o   = irq_q;

    // R4
    zero_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q == (value_q == '0));
    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (value_q == $past(wcount)));
    // R5
    hold_without_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr) |=> $stable(value_q));
    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (value_q == '0));
    // R7
    write_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !irq_o);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

// File: rtl/tmr_bus.sv
// Slave-side response: acknowledge, stall and read word assembly.
// Assumes: CNT_W <= DATA_W-2; the register is always readable, so no wait.
module tmr_bus #(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              auto,
    input  logic [CNT_W-1:0]  value,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_W = DATA_W - 1 - CNT_W;

    logic ack_q;

    // Acknowledge: one cycle after every strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= bus_stb;
    end

    assign bus_ack   = ack_q;
    assign bus_stall = 1'b0;
    assign bus_rdata = {auto, {PAD_W{1'b0}}, value};
endmodule

// File: rtl/evt_timer.sv
// Top level: one-register countdown timer with optional periodic reload.
// Assumes: CNT_W <= DATA_W-2; bus bits between the count and the mode bit
// carry nothing and are dropped here.
module evt_timer #(
    parameter int CNT_W     = 24,
    parameter int DATA_W    = 32,
    parameter bit RELOAD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             wr;
    logic             auto;
    logic [CNT_W-1:0] interval;
    logic [CNT_W-1:0] value;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-2:CNT_W];

    tmr_ctrl #(.CNT_W(CNT_W), .RELOAD_EN(RELOAD_EN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .wcount    (bus_wdata[CNT_W-1:0]),
        .wmode     (bus_wdata[DATA_W-1]),
        .wr_o      (wr),
        .auto_o    (auto),
        .interval_o(interval)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .wr      (wr),
        .wcount  (bus_wdata[CNT_W-1:0]),
        .auto    (auto),
        .interval(interval),
        .value_o (value),
        .irq_o   (irq)
    );

    tmr_bus #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_stb  (bus_stb),
        .auto     (auto),
        .value    (value),
        .bus_ack  (bus_ack),
        .bus_stall(bus_stall),
        .bus_rdata(bus_rdata)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (value == '0 && !auto && !irq && !bus_ack));
    // R8
    read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_we && !cnt_en) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
    localparam int CW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          bus_stb = 1'b0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ack, bus_stall, irq;
    logic [DW-1:0] bus_rdata;
    logic          ack_nr, stall_nr, irq_nr;
    logic [DW-1:0] rdata_nr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evt_timer #(.CNT_W(CW), .DATA_W(DW), .RELOAD_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_stall(bus_stall), .bus_rdata(bus_rdata), .irq(irq));

    evt_timer #(.CNT_W(CW), .DATA_W(DW), .RELOAD_EN(1'b0)) dut_nr (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_ack(ack_nr),
        .bus_stall(stall_nr), .bus_rdata(rdata_nr), .irq(irq_nr));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic do_write(input logic [31:0] d);
        bus_stb = 1'b1; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic tick(input bit en);
        cnt_en = en;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rd(input bit a, input int v);
        return {a, 26'b0, v[4:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
        chk(!irq && !bus_ack, "R1 irq/ack after reset", {irq, bus_ack}, 0);
        chk(bus_stall == 1'b0, "R8 stall", bus_stall, 0);

        // R8: write acknowledged next cycle, then drops
        do_write(32'h0000_0004);
        chk(bus_ack == 1'b1, "R8 ack after write", bus_ack, 1);
        tick(0);
        chk(bus_ack == 1'b0, "R8 ack drops", bus_ack, 0);
        // R8: read strobe changes nothing, still acknowledged
        bus_stb = 1'b1; bus_we = 1'b0; bus_wdata = 32'h0000_0011;
        @(negedge clk);
        bus_stb = 1'b0;
        chk(bus_ack == 1'b1, "R8 ack after read", bus_ack, 1);
        chk(bus_rdata == rd(0, 4), "R8 read leaves count", bus_rdata, rd(0, 4));
        chk(bus_stall == 1'b0, "R8 stall stays low", bus_stall, 0);

        // Sweep every count and both mode bits (R2 R3 R4 R6 R9 R10)
        for (int n = 0; n < 32; n++) begin
            for (int m = 0; m < 2; m++) begin
                bit a;
                a = (m == 1) && (n != 0);
                do_write((32'(m) << 31) | 32'(n));
                chk(bus_rdata == rd(a, n), "R3 mode/count readback", bus_rdata, rd(a, n));
                chk(rdata_nr == rd(0, n), "R10 no reload flag", rdata_nr, rd(0, n));
                chk(!irq, "R6 no irq after write", irq, 0);
                for (int k = 1; k <= 2 * (n + 1) + 1; k++) begin
                    int ev, eo;
                    bit ei, eio;
                    tick(1);
                    eo  = (k >= n) ? 0 : n - k;
                    eio = (n != 0) && (k == n);
                    ev  = a ? n - (k % (n + 1)) : eo;
                    ei  = a ? ((k % (n + 1)) == n) : eio;
                    chk(bus_rdata == rd(a, ev), "R4 count sequence", bus_rdata, rd(a, ev));
                    chk(irq == ei, "R6 irq timing", irq, ei);
                    chk(rdata_nr == rd(0, eo), "R10 one-shot only", rdata_nr, rd(0, eo));
                    chk(irq_nr == eio, "R10 irq one-shot", irq_nr, eio);
                end
                cnt_en = 1'b0;
            end
        end

        // R5: hold while enable is low, then step only on enabled cycles
        do_write(32'h0000_0007);
        tick(0); tick(0); tick(0);
        chk(bus_rdata == rd(0, 7), "R5 hold without enable", bus_rdata, rd(0, 7));
        tick(1); tick(0); tick(1); tick(0);
        chk(bus_rdata == rd(0, 5), "R5 gated steps", bus_rdata, rd(0, 5));

        // R6: waiting at zero for reload, no irq
        do_write(32'h8000_0001);
        tick(1);
        chk(irq == 1'b1, "R6 irq at zero", irq, 1);
        tick(0);
        chk(irq == 1'b0 && bus_rdata == rd(1, 0), "R6 waiting quiet", {irq, bus_rdata[4:0]}, 0);
        tick(0);
        chk(irq == 1'b0, "R6 still quiet", irq, 0);
        tick(1);
        chk(bus_rdata == rd(1, 1) && !irq, "R4 reload on enable", bus_rdata, rd(1, 1));

        // R2: zero write stops periodic mode
        do_write(32'h8000_0003);
        tick(1); tick(1);
        cnt_en = 1'b0;
        do_write(32'h0000_0000);
        chk(bus_rdata == 0, "R2 zero write clears", bus_rdata, 0);
        tick(1); tick(1); tick(1);
        chk(bus_rdata == 0 && !irq, "R2 stays stopped", bus_rdata, 0);
        cnt_en = 1'b0;

        // R9: middle bits ignored
        do_write(32'h7FFF_FFE3);
        chk(bus_rdata == rd(0, 3), "R9 middle bits ignored", bus_rdata, rd(0, 3));
        // R3: top bit with zero count gives no periodic mode
        do_write(32'h8000_0000);
        chk(bus_rdata == 0, "R3 periodic refused at zero", bus_rdata, 0);

        // R7: write collides with enabled step at 1
        do_write(32'h0000_0002);
        tick(1);
        chk(bus_rdata == rd(0, 1), "R7 setup at one", bus_rdata, rd(0, 1));
        bus_stb = 1'b1; bus_we = 1'b1; bus_wdata = 32'h0000_0006;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
        chk(bus_rdata == rd(0, 6), "R7 new value loaded", bus_rdata, rd(0, 6));
        chk(irq == 1'b0, "R7 no irq", irq, 0);
        tick(1);
        chk(irq == 1'b0 && bus_rdata == rd(0, 5), "R7 continues", bus_rdata, rd(0, 5));
        cnt_en = 1'b0;

        // R1: reset wins over a same-cycle write
        rst_n = 1'b0; bus_stb = 1'b1; bus_we = 1'b1; bus_wdata = 32'h8000_0009;
        @(negedge clk);
        rst_n = 1'b1; bus_stb = 1'b0; bus_we = 1'b0;
        chk(bus_rdata == 0 && !irq && !bus_ack, "R1 reset beats write", bus_rdata, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule